// File: doc/BRIEF.md
# Zero-overhead loop sequencer

This block generates the program counter for a processor that runs hardware loops without branch instructions. It advances the PC by one instruction each cycle. When the decoder sees a loop-setup instruction, it raises a command together with the address of the last instruction in the body and an exit rule. The exit rule is either an iteration count or a termination condition. The sequencer saves the address that follows the setup instruction as the loop start. From then on it compares the PC with the saved end address in hardware and branches back to the start by itself.

Loops can be nested up to a parameterised depth, held on a small stack. The innermost loop is the one being compared. When the innermost loop exits, it is popped and the enclosing loop takes over. A setup command while the stack is full is dropped, and an error flag pulses for one cycle.

A separate repeat command executes the next single instruction a given number of times. A repeat count of zero means 256. The PC holds on that instruction while the repeat runs. An interrupt-hold output tells the interrupt logic to wait. A stall input freezes every piece of state.

Top module: `zol_seq`

## Requirements
- R1: After a synchronous reset, `pc_o` equals `RESET_PC`, and `loop_active_o`, `irq_hold_o` and `ovf_o` are 0.
- R2: With no loop active and no repeat running, `pc_o` rises by exactly 1 on every non-stalled clock edge.
- R3: A loop command taken at PC value P saves P+1 as the loop start. `pc_o` becomes P+1, and `loop_active_o` is 1 after that edge.
- R4: In count mode (`loop_mode_i` = 0) with count C ≥ 1, each time `pc_o` equals the end address the PC returns to the start. On the C-th arrival at the end address it goes to end+1 instead and the loop is removed.
- R5: A count of 0 in count mode runs the body 2^CW times (65536 with the default width) before falling through.
- R6: In condition mode (`loop_mode_i` = 1), at the end address the PC returns to the start while `cond_i` is 0. It falls through to end+1 and removes the loop when `cond_i` is 1.
- R7: A repeat command with count N taken at PC value P makes `pc_o` equal P+1 for exactly N consecutive non-stalled cycles (N = 0 means 256), then P+2. `irq_hold_o` is 1 for exactly those cycles.
- R8: Up to DEPTH (default 4) loops nest. When an inner loop exits at its end address, the enclosing loop continues and is itself tested at its own end address.
- R9: A loop command while DEPTH loops are active is ignored and leaves the loop state unchanged. `ovf_o` is 1 for the cycle after that edge and 0 otherwise.
- R10: While `stall_i` is 1, `pc_o`, `loop_active_o`, `irq_hold_o`, `ovf_o` and all loop and repeat state hold their values.
- R11: Loop and repeat commands that arrive while a repeat is running are ignored. A loop command wins over a repeat command given in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Freeze all state this cycle |
| loop_go_i | input | 1 | Loop-setup command at the current PC |
| loop_end_i | input | AW | Address of the last instruction of the loop body |
| loop_cnt_i | input | CW | Iteration count for count mode (0 means 2^CW) |
| loop_mode_i | input | 1 | 0 = count mode, 1 = condition mode |
| cond_i | input | 1 | Termination condition, tested at the end address in condition mode |
| rpt_go_i | input | 1 | Single-instruction repeat command at the current PC |
| rpt_cnt_i | input | RW | Repeat count (0 means 2^RW) |
| pc_o | output | AW | Program counter |
| loop_active_o | output | 1 | At least one loop is on the stack |
| irq_hold_o | output | 1 | Interrupts must wait: a repeat is running |
| ovf_o | output | 1 | One-cycle pulse when a loop command hit a full stack |

## Verification
A corrupted start or end register appears on `pc_o` at the first arrival at the loop end: the PC jumps to the wrong address or fails to jump. An off-by-one in the iteration counter appears only on the last pass, as one body too many or one too few before the fall-through. A wrong stack pointer surfaces when an inner loop exits: the PC keeps looping at the inner end, or the outer loop never branches back. A wrong repeat counter shows directly as the number of cycles `irq_hold_o` stays high while `pc_o` sits still.

// File: rtl/zol_pkg.sv
package zol_pkg;
  typedef enum logic {
    MODE_COUNT = 1'b0,
    MODE_COND  = 1'b1
  } loop_mode_e;
endpackage

// File: rtl/zol_stack.sv
module zol_stack #(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          push,
  input  logic          pop,
  input  logic          dec,
  input  logic [AW-1:0] push_start,
  input  logic [AW-1:0] push_end,
  input  logic [CW-1:0] push_cnt,
  input  logic          push_mode,
  output logic [AW-1:0] top_start,
  output logic [AW-1:0] top_end,
  output logic [CW-1:0] top_cnt,
  output logic          top_mode,
  output logic          empty,
  output logic          full
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0] sp;
  logic [AW-1:0] st_start [DEPTH];
  logic [AW-1:0] st_end   [DEPTH];
  logic [CW-1:0] st_cnt   [DEPTH];
  logic          st_mode  [DEPTH];
  logic [IW-1:0] wr_idx, top_idx;

  assign wr_idx  = IW'(sp);
  assign top_idx = IW'(sp - PW'(1));
  assign empty   = (sp == '0);
  assign full    = (sp == PW'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= '0;
    end else if (en) begin
      if (push)     sp <= sp + PW'(1);
      else if (pop) sp <= sp - PW'(1);
    end
  end

  // entry storage: no reset, written at one port, read at the top
  always_ff @(posedge clk) begin
    if (en) begin
      if (push) begin
        st_start[wr_idx] <= push_start;
        st_end[wr_idx]   <= push_end;
        st_cnt[wr_idx]   <= push_cnt;
        st_mode[wr_idx]  <= push_mode;
      end else if (dec) begin
        st_cnt[top_idx] <= st_cnt[top_idx] - CW'(1);
      end
    end
  end

  assign top_start = st_start[top_idx];
  assign top_end   = st_end[top_idx];
  assign top_cnt   = st_cnt[top_idx];
  assign top_mode  = st_mode[top_idx];
endmodule

// File: rtl/zol_repeat.sv
module zol_repeat #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          go,
  input  logic [RW-1:0] cnt,
  output logic          active,
  output logic          last
);
  logic [RW:0] left;
  logic [RW:0] load_val;

  // zero selects the full range 2^RW
  assign load_val = (cnt == '0) ? {1'b1, {RW{1'b0}}} : {1'b0, cnt};
  assign last     = active && (left == (RW+1)'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      left   <= '0;
    end else if (en) begin
      if (go && !active) begin
        active <= 1'b1;
        left   <= load_val;
      end else if (active) begin
        if (left == (RW+1)'(1)) active <= 1'b0;
        left <= left - (RW+1)'(1);
      end
    end
  end
endmodule

// File: rtl/zol_seq.sv
module zol_seq #(
  parameter int AW       = 16,
  parameter int CW       = 16,
  parameter int RW       = 8,
  parameter int DEPTH    = 4,
  parameter int RESET_PC = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall_i,
  input  logic          loop_go_i,
  input  logic [AW-1:0] loop_end_i,
  input  logic [CW-1:0] loop_cnt_i,
  input  logic          loop_mode_i,
  input  logic          cond_i,
  input  logic          rpt_go_i,
  input  logic [RW-1:0] rpt_cnt_i,
  output logic [AW-1:0] pc_o,
  output logic          loop_active_o,
  output logic          irq_hold_o,
  output logic          ovf_o
);
  import zol_pkg::*;

  logic          en;
  logic [AW-1:0] pc_q, pc_inc, pc_next;
  logic          ovf_q;
  logic          rpt_active, rpt_last;
  logic [AW-1:0] top_start, top_end;
  logic [CW-1:0] top_cnt;
  logic          top_mode;
  logic          st_empty, st_full;
  logic          cmd_ok, do_loop, do_rpt, advance, at_end, exit_now;
  logic          take_back, do_pop, do_dec, do_push, do_ovf;

  assign en      = !stall_i;
  assign pc_inc  = pc_q + AW'(1);
  assign cmd_ok  = !rpt_active;
  assign do_loop = loop_go_i && cmd_ok;
  assign do_rpt  = rpt_go_i && cmd_ok && !loop_go_i;
  assign advance = !rpt_active || rpt_last;

  assign at_end   = !st_empty && advance && !do_loop && !do_rpt && (pc_q == top_end);
  assign exit_now = (loop_mode_e'(top_mode) == MODE_COND) ? cond_i : (top_cnt == CW'(1));

  assign take_back = at_end && !exit_now;
  assign do_pop    = at_end && exit_now;
  assign do_dec    = take_back && (loop_mode_e'(top_mode) == MODE_COUNT);
  assign do_push   = do_loop && !st_full;
  assign do_ovf    = do_loop && st_full;

  always_comb begin
    if (!advance)      pc_next = pc_q;
    else if (take_back) pc_next = top_start;
    else               pc_next = pc_inc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= AW'(RESET_PC);
      ovf_q <= 1'b0;
    end else if (en) begin
      pc_q  <= pc_next;
      ovf_q <= do_ovf;
    end
  end

  zol_stack #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_stack (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .push       (do_push),
    .pop        (do_pop),
    .dec        (do_dec),
    .push_start (pc_inc),
    .push_end   (loop_end_i),
    .push_cnt   (loop_cnt_i),
    .push_mode  (loop_mode_i),
    .top_start  (top_start),
    .top_end    (top_end),
    .top_cnt    (top_cnt),
    .top_mode   (top_mode),
    .empty      (st_empty),
    .full       (st_full)
  );

  zol_repeat #(.RW(RW)) u_rpt (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .go     (do_rpt),
    .cnt    (rpt_cnt_i),
    .active (rpt_active),
    .last   (rpt_last)
  );

  assign pc_o          = pc_q;
  assign loop_active_o = !st_empty;
  assign irq_hold_o    = rpt_active;
  assign ovf_o         = ovf_q;
endmodule

// File: rtl/zol_seq_chk.sv
module zol_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          stall_i,
  input logic          loop_go_i,
  input logic          rpt_go_i,
  input logic [AW-1:0] pc_o,
  input logic          loop_active_o,
  input logic          irq_hold_o,
  input logic          ovf_o
);
  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && !irq_hold_o && !loop_active_o) |=> (pc_o == $past(pc_o) + AW'(1)));

  // R10
  stall_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    stall_i |=> ($stable(pc_o) && $stable(loop_active_o) && $stable(irq_hold_o) && $stable(ovf_o)));

  // R3
  loop_start_chk: assert property (@(posedge clk) disable iff (rst)
    (loop_go_i && !stall_i && !irq_hold_o) |=> loop_active_o);

  // R7
  rpt_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_hold_o) |-> ($past(rpt_go_i) && !$past(loop_go_i)));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_o) |-> ($past(loop_go_i) && loop_active_o));

  // R11
  rpt_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_hold_o && !stall_i && loop_go_i && !loop_active_o) |=> !loop_active_o);
endmodule

bind zol_seq zol_seq_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .stall_i       (stall_i),
  .loop_go_i     (loop_go_i),
  .rpt_go_i      (rpt_go_i),
  .pc_o          (pc_o),
  .loop_active_o (loop_active_o),
  .irq_hold_o    (irq_hold_o),
  .ovf_o         (ovf_o)
);

// File: tb/zol_seq_test.sv
`timescale 1ns/1ps
module zol_seq_test;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          stall_i = 0, loop_go_i = 0, loop_mode_i = 0, cond_i = 0, rpt_go_i = 0;
  logic [AW-1:0] loop_end_i = '0;
  logic [CW-1:0] loop_cnt_i = '0;
  logic [RW-1:0] rpt_cnt_i = '0;
  logic [AW-1:0] pc_o;
  logic          loop_active_o, irq_hold_o, ovf_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  zol_seq #(.AW(AW), .CW(CW), .RW(RW), .DEPTH(4), .RESET_PC(0)) uut (
    .clk(clk), .rst(rst), .stall_i(stall_i), .loop_go_i(loop_go_i),
    .loop_end_i(loop_end_i), .loop_cnt_i(loop_cnt_i), .loop_mode_i(loop_mode_i),
    .cond_i(cond_i), .rpt_go_i(rpt_go_i), .rpt_cnt_i(rpt_cnt_i),
    .pc_o(pc_o), .loop_active_o(loop_active_o), .irq_hold_o(irq_hold_o), .ovf_o(ovf_o)
  );

  typedef struct packed {
    logic          stall;
    logic          go;
    logic [15:0]   lend;
    logic [15:0]   lcnt;
    logic          mode;
    logic          cond;
    logic          rgo;
    logic [7:0]    rcnt;
    logic [15:0]   epc;
    logic          eact;
    logic          eirq;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,16'd0, 16'd0,1'b0,1'b0,1'b0,8'd0, 16'd1, 1'b0,1'b0}, // R2
    '{1'b0,1'b1,16'd3, 16'd2,1'b0,1'b0,1'b0,8'd0, 16'd2, 1'b1,1'b0}, // R3
    '{1'b0,1'b0,16'd0, 16'd0,1'b0,1'b0,1'b0,8'd0, 16'd3, 1'b1,1'b0},
    '{1'b0,1'b0,16'd0, 16'd0,1'b0,1'b0,1'b0,8'd0, 16'd2, 1'b1,1'b0}, // R4 back
    '{1'b0,1'b0,16'd0, 16'd0,1'b0,1'b0,1'b0,8'd0, 16'd3, 1'b1,1'b0},
    '{1'b0,1'b0,16'd0, 16'd0,1'b0,1'b0,1'b0,8'd0, 16'd4, 1'b0,1'b0}, // R4 exit
    '{1'b0,1'b1,16'd6, 16'd0,1'b1,1'b0,1'b0,8'd0, 16'd5, 1'b1,1'b0}, // R6
    '{1'b0,1'b0,16'd0, 16'd0,1'b0,1'b0,1'b0,8'd0, 16'd6, 1'b1,1'b0},
    '{1'b0,1'b0,16'd0, 16'd0,1'b0,1'b0,1'b0,8'd0, 16'd5, 1'b1,1'b0}, // R6 back
    '{1'b1,1'b0,16'd0, 16'd0,1'b0,1'b0,1'b0,8'd0, 16'd5, 1'b1,1'b0}, // R10
    '{1'b0,1'b0,16'd0, 16'd0,1'b0,1'b0,1'b0,8'd0, 16'd6, 1'b1,1'b0},
    '{1'b0,1'b0,16'd0, 16'd0,1'b0,1'b1,1'b0,8'd0, 16'd7, 1'b0,1'b0}, // R6 exit
    '{1'b0,1'b0,16'd0, 16'd0,1'b0,1'b0,1'b1,8'd3, 16'd8, 1'b0,1'b1}, // R7
    '{1'b0,1'b1,16'd20,16'd5,1'b0,1'b0,1'b0,8'd0, 16'd8, 1'b0,1'b1}, // R11
    '{1'b0,1'b0,16'd0, 16'd0,1'b0,1'b0,1'b1,8'd9, 16'd8, 1'b0,1'b1}, // R11
    '{1'b0,1'b0,16'd0, 16'd0,1'b0,1'b0,1'b0,8'd0, 16'd9, 1'b0,1'b0}, // R7 end
    '{1'b0,1'b0,16'd0, 16'd0,1'b0,1'b0,1'b0,8'd0, 16'd10,1'b0,1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic st, input logic go, input logic [15:0] lend,
                      input logic [15:0] lcnt, input logic mode, input logic cond,
                      input logic rgo, input logic [7:0] rcnt);
    stall_i = st; loop_go_i = go; loop_end_i = lend; loop_cnt_i = lcnt;
    loop_mode_i = mode; cond_i = cond; rpt_go_i = rgo; rpt_cnt_i = rcnt;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    stall_i = 0; loop_go_i = 0; rpt_go_i = 0; cond_i = 0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int k;
    do_reset();
    // R1
    chk("R1 pc", pc_o, 0);
    chk("R1 active", loop_active_o, 0);
    chk("R1 irq", irq_hold_o, 0);
    chk("R1 ovf", ovf_o, 0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].stall, VECS[i].go, VECS[i].lend, VECS[i].lcnt,
           VECS[i].mode, VECS[i].cond, VECS[i].rgo, VECS[i].rcnt);
      chk($sformatf("R4/R6/R7/R10/R11 vec%0d pc", i), pc_o, VECS[i].epc);
      chk($sformatf("R3/R4/R6 vec%0d active", i), loop_active_o, VECS[i].eact);
      chk($sformatf("R7/R11 vec%0d irq", i), irq_hold_o, VECS[i].eirq);
    end

    // R5: zero count on a one-instruction body runs 65536 passes
    do_reset();
    step(0, 1, 16'd1, 16'd0, 0, 0, 0, 0);
    k = 0;
    while (pc_o == 16'd1 && k < 70000) begin k++; idle(); end
    chk("R5 passes", k, 65536);
    chk("R5 fall-through pc", pc_o, 2);
    chk("R5 inactive", loop_active_o, 0);

    // R7: repeat count 0 holds for 256 cycles
    step(0, 0, 0, 0, 0, 0, 1, 8'd0);
    chk("R7 target pc", pc_o, 3);
    k = 0;
    while (irq_hold_o && k < 400) begin
      if (pc_o != 16'd3) k = 1000;
      k++; idle();
    end
    chk("R7 repeat 256", k, 256);
    chk("R7 after repeat pc", pc_o, 4);

    // R8 and R9: four nested loops, fifth rejected
    do_reset();
    step(0, 1, 16'd10, 16'd2, 0, 0, 0, 0);  // pc0 -> outer, start 1
    step(0, 1, 16'd9,  16'd1, 0, 0, 0, 0);  // pc1
    step(0, 1, 16'd8,  16'd1, 0, 0, 0, 0);  // pc2
    step(0, 1, 16'd7,  16'd1, 0, 0, 0, 0);  // pc3, stack full
    chk("R8 pc", pc_o, 4);
    chk("R9 no pulse yet", ovf_o, 0);
    step(0, 1, 16'd5,  16'd2, 0, 0, 0, 0);  // pc4, rejected
    chk("R9 ovf pulse", ovf_o, 1);
    chk("R9 pc", pc_o, 5);
    idle();
    chk("R9 ovf clears", ovf_o, 0);
    chk("R9 ignored loop not taken", pc_o, 6);
    idle(); chk("R8 pc7", pc_o, 7);
    idle(); chk("R8 inner exit", pc_o, 8);
    idle(); chk("R8 pc9", pc_o, 9);
    idle(); chk("R8 pc10", pc_o, 10);
    idle(); chk("R8 outer back", pc_o, 1);
    chk("R8 outer still active", loop_active_o, 1);
    for (int j = 2; j <= 10; j++) idle();
    chk("R8 pc10 second pass", pc_o, 10);
    idle();
    chk("R8 outer exit", pc_o, 11);
    chk("R8 all popped", loop_active_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule